// File: doc/BRIEF.md
# TDM Serial Slave Receiver

This block takes in a time-division-multiplexed serial stream from an external master. The master drives the bit clock and the frame sync. The block runs on a faster system clock. It brings the three serial lines into that domain through synchronizer chains, then works out when each bit should be sampled. The system clock must run at least four times faster than the bit clock.

A frame starts on one chosen edge of the frame sync. How long the sync stays asserted makes no difference. The block shifts in a fixed number of fixed-width slots and hands each finished word, with its slot number, to a one-deep valid/ready output register.

Frame-sync timing faults raise sticky flags, and so does an output word that is never collected. A one-cycle clear input resets all three flags. After a sync fault, received data is dropped until the next active sync edge puts the receiver back in step.

Top module: `tdm_slave_rx`

## Requirements
- R1: Each frame holds 4 slots of 32 bits, for 128 bit periods in all. Bits arrive MSB first. Each finished slot gives one output beat. The beat carries the 32-bit word and a 2-bit slot number that runs 0, 1, 2, 3 within the frame.
- R2: `cfg_fs_rise` = 1 makes a low-to-high change of the frame sync mark a frame start. `cfg_fs_rise` = 0 makes a high-to-low change mark it.
- R3: Only the active sync edge counts. The width of the sync pulse is ignored, and the opposite edge has no effect on slot alignment or on the output words.
- R4: With `cfg_offset` = 0, the MSB of slot 0 is the bit sampled in the bit period where the active sync edge is seen. With `cfg_offset` = 1, it is the bit sampled one bit period later.
- R5: If `cfg_offset` does not match the stream, every word is shifted by one bit. A stream with a one-bit offset read with `cfg_offset` = 0 gives words that start one bit early. A stream with no offset read with `cfg_offset` = 1 gives words that start one bit late.
- R6: If 128 bit periods pass after an active sync edge with no new active edge, `err_late` is set. Data is then dropped until the next active edge, and no beats are produced.
- R7: If an active sync edge arrives fewer than 128 bit periods after the previous one, `err_early` is set. The partly received slot is dropped and a new frame starts at that edge.
- R8: `cfg_sample_rise` = 1 samples the data and sync lines on the rising bit-clock edge. `cfg_sample_rise` = 0 samples them on the falling edge.
- R9: `err_late`, `err_early` and `err_overrun` stay set until `err_clear` is high for one cycle. If a new error arrives in the same cycle as the clear, the flag stays set.
- R10: Once `out_valid` is high, `out_data` and `out_slot` stay stable until `out_ready` is seen. If a new word completes while the held word has not been accepted, `err_overrun` is set and the new word replaces the held one.
- R11: After reset, `out_valid`, `err_late`, `err_early` and `err_overrun` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fs_rise | input | 1 | 1: rising sync edge starts a frame; 0: falling edge |
| cfg_offset | input | 1 | 1: first data bit comes one bit period after the sync edge |
| cfg_sample_rise | input | 1 | 1: sample on rising bit-clock edge; 0: on falling edge |
| err_clear | input | 1 | One-cycle pulse that clears all sticky flags |
| bck_i | input | 1 | Serial bit clock from the master |
| fs_i | input | 1 | Frame sync from the master |
| sd_i | input | 1 | Serial data from the master |
| out_ready | input | 1 | Consumer accepts the held word |
| out_valid | output | 1 | A received word is held |
| out_data | output | 32 | Received slot word |
| out_slot | output | 2 | Slot number of the held word |
| err_late | output | 1 | Sticky: no sync edge by the end of the frame |
| err_early | output | 1 | Sticky: sync edge came before the frame ended |
| err_overrun | output | 1 | Sticky: a word was lost because the output was not read |

## Verification
The bench sends random data words in streams that differ in sync polarity, sync pulse width, offset and sampling edge. It then compares each beat with words cut from the transmitted bit array at the position the requirements predict. This separates a correct frame start from a start that is one bit early, one bit late, or tied to the trailing edge of a wide sync.

Mismatched offset settings check that the word boundary moves by exactly one bit in each direction. Directed streams with a missing sync, a premature sync and a stalled consumer check that each fault sets only its own flag. They also check that the right words are dropped or overwritten.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

    // One sampled bit period as seen by the framer.
    typedef struct packed {
        logic tick;     // a sampling edge of the bit clock occurred
        logic fs_edge;  // the active sync edge was seen at this tick
        logic sd;       // data bit sampled at this tick
    } rx_bit_t;

    // One-cycle frame-sync fault pulses.
    typedef struct packed {
        logic late;
        logic early;
    } fs_err_t;

    function automatic logic clk_edge(logic now, logic prev, logic rise);
        return rise ? (now && !prev) : (!now && prev);
    endfunction

    function automatic logic sync_edge(logic now, logic prev, logic act);
        return (now == act) && (prev != act);
    endfunction

endpackage

// File: rtl/tdm_rx_sync.sv
module tdm_rx_sync
    import tdm_rx_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    cfg_fs_rise,
    input  logic    cfg_sample_rise,
    input  logic    bck_i,
    input  logic    fs_i,
    input  logic    sd_i,
    output rx_bit_t bit_o
);
    localparam int unsigned LANES = 3;

    logic [LANES-1:0] raw;
    logic [LANES-1:0] synced;
    assign raw = {bck_i, fs_i, sd_i};

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], raw[g]};
            end
            assign synced[g] = chain[STAGES-1];
        end
    endgenerate

    logic bck_prev;
    logic fs_prev;
    logic tick;

    assign tick = clk_edge(synced[2], bck_prev, cfg_sample_rise);

    always_ff @(posedge clk) begin
        if (rst) begin
            bck_prev <= 1'b0;
            fs_prev  <= ~cfg_fs_rise;
        end else begin
            bck_prev <= synced[2];
            if (tick) fs_prev <= synced[1];
        end
    end

    always_comb begin
        bit_o.tick    = tick;
        bit_o.fs_edge = tick && sync_edge(synced[1], fs_prev, cfg_fs_rise);
        bit_o.sd      = synced[0];
    end
endmodule

// File: rtl/tdm_rx_framer.sv
module tdm_rx_framer
    import tdm_rx_pkg::*;
#(
    parameter int unsigned SLOT_W  = 32,
    parameter int unsigned N_SLOTS = 4,
    parameter int unsigned SIW     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_offset,
    input  rx_bit_t           bit_i,
    output logic              word_vld,
    output logic [SLOT_W-1:0] word,
    output logic [SIW-1:0]    word_slot,
    output fs_err_t           err_p
);
    localparam int unsigned FRAME_LEN = SLOT_W * N_SLOTS;
    localparam int unsigned PW        = $clog2(FRAME_LEN);
    localparam logic [PW-1:0] LAST    = PW'(FRAME_LEN - 1);
    localparam logic [PW-1:0] SLOT_LAST = PW'(SLOT_W - 1);

    logic              aligned;
    logic              start_pend;
    logic              seen;
    logic [PW-1:0]     since;
    logic [PW-1:0]     pos;
    logic [SLOT_W-1:0] shreg;

    logic          early_now, late_now, start_now, cont, shift_en;
    logic [PW-1:0] cur_pos;

    always_comb begin
        early_now = bit_i.fs_edge && seen && (since < LAST);
        late_now  = bit_i.tick && !bit_i.fs_edge && seen && (since == LAST);
        start_now = bit_i.tick && ((bit_i.fs_edge && !cfg_offset) || start_pend);
        cont      = bit_i.tick && aligned && !start_now && !early_now && !late_now;
        shift_en  = start_now || cont;
        cur_pos   = start_now ? '0 : pos;
        word      = {shreg[SLOT_W-2:0], bit_i.sd};
        word_vld  = shift_en && ((cur_pos % PW'(SLOT_W)) == SLOT_LAST);
        word_slot = SIW'(cur_pos / PW'(SLOT_W));
        err_p.late  = late_now;
        err_p.early = early_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            aligned    <= 1'b0;
            start_pend <= 1'b0;
            seen       <= 1'b0;
            since      <= '0;
            pos        <= '0;
            shreg      <= '0;
        end else if (bit_i.tick) begin
            start_pend <= bit_i.fs_edge && cfg_offset;
            if (bit_i.fs_edge) begin
                seen  <= 1'b1;
                since <= '0;
            end else if (late_now) begin
                seen <= 1'b0;
            end else if (seen && since != LAST) begin
                since <= since + 1'b1;
            end
            if (shift_en) begin
                shreg   <= word;
                pos     <= cur_pos + 1'b1;
                aligned <= (cur_pos != LAST);
            end else if (early_now || late_now) begin
                aligned <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tdm_rx_outreg.sv
module tdm_rx_outreg
    import tdm_rx_pkg::*;
#(
    parameter int unsigned SLOT_W = 32,
    parameter int unsigned SIW    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_vld,
    input  logic [SLOT_W-1:0] word,
    input  logic [SIW-1:0]    word_slot,
    input  fs_err_t           err_p,
    input  logic              err_clear,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [SLOT_W-1:0] out_data,
    output logic [SIW-1:0]    out_slot,
    output logic              err_late,
    output logic              err_early,
    output logic              err_overrun
);
    logic ovr_p;
    assign ovr_p = word_vld && out_valid && !out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_data    <= '0;
            out_slot    <= '0;
            err_late    <= 1'b0;
            err_early   <= 1'b0;
            err_overrun <= 1'b0;
        end else begin
            if (word_vld) begin
                out_valid <= 1'b1;
                out_data  <= word;
                out_slot  <= word_slot;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
            err_late    <= (err_late    && !err_clear) || err_p.late;
            err_early   <= (err_early   && !err_clear) || err_p.early;
            err_overrun <= (err_overrun && !err_clear) || ovr_p;
        end
    end
endmodule

// File: rtl/tdm_slave_rx.sv
module tdm_slave_rx
    import tdm_rx_pkg::*;
#(
    parameter int unsigned SLOT_W      = 32,
    parameter int unsigned N_SLOTS     = 4,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned SIW = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_fs_rise,
    input  logic              cfg_offset,
    input  logic              cfg_sample_rise,
    input  logic              err_clear,
    input  logic              bck_i,
    input  logic              fs_i,
    input  logic              sd_i,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [SLOT_W-1:0] out_data,
    output logic [SIW-1:0]    out_slot,
    output logic              err_late,
    output logic              err_early,
    output logic              err_overrun
);
    rx_bit_t           bit_w;
    logic              word_vld;
    logic [SLOT_W-1:0] word;
    logic [SIW-1:0]    word_slot;
    fs_err_t           err_p;

    tdm_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk             (clk),
        .rst             (rst),
        .cfg_fs_rise     (cfg_fs_rise),
        .cfg_sample_rise (cfg_sample_rise),
        .bck_i           (bck_i),
        .fs_i            (fs_i),
        .sd_i            (sd_i),
        .bit_o           (bit_w)
    );

    tdm_rx_framer #(.SLOT_W(SLOT_W), .N_SLOTS(N_SLOTS), .SIW(SIW)) u_framer (
        .clk        (clk),
        .rst        (rst),
        .cfg_offset (cfg_offset),
        .bit_i      (bit_w),
        .word_vld   (word_vld),
        .word       (word),
        .word_slot  (word_slot),
        .err_p      (err_p)
    );

    tdm_rx_outreg #(.SLOT_W(SLOT_W), .SIW(SIW)) u_out (
        .clk         (clk),
        .rst         (rst),
        .word_vld    (word_vld),
        .word        (word),
        .word_slot   (word_slot),
        .err_p       (err_p),
        .err_clear   (err_clear),
        .out_ready   (out_ready),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .out_slot    (out_slot),
        .err_late    (err_late),
        .err_early   (err_early),
        .err_overrun (err_overrun)
    );
endmodule

// File: rtl/tdm_rx_checker.sv
module tdm_rx_checker #(
    parameter int unsigned SLOT_W = 32,
    parameter int unsigned SIW    = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              err_clear,
    input logic              out_ready,
    input logic              out_valid,
    input logic [SLOT_W-1:0] out_data,
    input logic [SIW-1:0]    out_slot,
    input logic              err_late,
    input logic              err_overrun,
    input logic              word_vld,
    input logic              late_p
);
    // R1: every completed slot shows up as a held beat
    assert_beat_R1: assert property (@(posedge clk) disable iff (rst)
        word_vld |=> out_valid);

    // R10: a held, unaccepted beat stays put while no new word arrives
    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !word_vld) |=>
            (out_valid && $stable(out_data) && $stable(out_slot)));

    // R10: a word completing onto an unaccepted beat flags overrun
    assert_overrun_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && word_vld) |=> err_overrun);

    // R9: flag stays set until cleared
    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (err_late && !err_clear) |=> err_late);

    // R9: clear without a fresh fault drops the flag
    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (err_clear && !late_p) |=> !err_late);
endmodule

bind tdm_slave_rx tdm_rx_checker #(.SLOT_W(SLOT_W), .SIW(SIW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .err_clear   (err_clear),
    .out_ready   (out_ready),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_slot    (out_slot),
    .err_late    (err_late),
    .err_overrun (err_overrun),
    .word_vld    (word_vld),
    .late_p      (err_p.late)
);

// File: tb/tb_tdm_slave_rx.sv
module tb_tdm_slave_rx;
    localparam int FL = 128;
    localparam int SW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_fs_rise = 1'b1, cfg_offset = 1'b0, cfg_sample_rise = 1'b1;
    logic err_clear = 1'b0, out_ready = 1'b1;
    logic bck_i = 1'b1, fs_i = 1'b0, sd_i = 1'b0;
    logic        out_valid;
    logic [31:0] out_data;
    logic [1:0]  out_slot;
    logic err_late, err_early, err_overrun;

    always #10 clk = ~clk;  // 50 MHz

    tdm_slave_rx dut (
        .clk(clk), .rst(rst), .cfg_fs_rise(cfg_fs_rise), .cfg_offset(cfg_offset),
        .cfg_sample_rise(cfg_sample_rise), .err_clear(err_clear),
        .bck_i(bck_i), .fs_i(fs_i), .sd_i(sd_i), .out_ready(out_ready),
        .out_valid(out_valid), .out_data(out_data), .out_slot(out_slot),
        .err_late(err_late), .err_early(err_early), .err_overrun(err_overrun)
    );

    int n_tests = 0;
    int n_fail  = 0;

    logic bit_fs [0:2047];
    logic bit_sd [0:2047];
    int   nb = 0;

    logic [31:0] rx_data [0:63];
    logic [1:0]  rx_slot [0:63];
    int          rx_cnt = 0;

    always @(negedge clk) begin
        if (!rst && out_valid && out_ready && rx_cnt < 64) begin
            rx_data[rx_cnt] = out_data;
            rx_slot[rx_cnt] = out_slot;
            rx_cnt = rx_cnt + 1;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ext(input int st);
        logic [31:0] r = '0;
        for (int i = 0; i < SW; i++) r = {r[30:0], bit_sd[st + i]};
        return r;
    endfunction

    task automatic push(input logic f, input logic d);
        bit_fs[nb] = f;
        bit_sd[nb] = d;
        nb++;
    endtask

    function automatic logic rbit();
        return 1'($urandom_range(0, 1));
    endfunction

    // Appends one frame of random data; act is the active sync level.
    task automatic add_frame(input int len, input logic off, input int width,
                             input logic act, input logic lead_next);
        for (int n = 0; n < len; n++) begin
            logic on;
            if (off) on = (n < width - 1) || (lead_next && n == len - 1);
            else     on = (n < width);
            push(on ? act : ~act, rbit());
        end
    endtask

    // Preamble bit (index 0) plus nf full frames; frame f starts at 1+f*FL.
    task automatic build(input int nf, input logic off, input int width, input logic act);
        nb = 0;
        push(off ? act : ~act, rbit());
        for (int f = 0; f < nf; f++) add_frame(FL, off, width, act, off);
    endtask

    task automatic bit_out(input logic f, input logic d);
        bck_i = cfg_sample_rise ? 1'b0 : 1'b1;   // launch edge
        fs_i  = f;
        sd_i  = d;
        repeat (4) @(negedge clk);
        bck_i = ~bck_i;                           // sampling edge
        repeat (4) @(negedge clk);
    endtask

    task automatic play();
        for (int i = 0; i < nb; i++) bit_out(bit_fs[i], bit_sd[i]);
        repeat (12) @(negedge clk);
    endtask

    task automatic do_reset(input logic fs_rise, input logic off, input logic srise);
        cfg_fs_rise     = fs_rise;
        cfg_offset      = off;
        cfg_sample_rise = srise;
        bck_i = srise;
        fs_i  = ~fs_rise;
        rst   = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        rx_cnt = 0;
    endtask

    task automatic check_beats(input string tag, input int first, input int st, input int n);
        for (int k = 0; k < n; k++) begin
            chk({tag, " data"}, 64'(rx_data[first + k]), 64'(ext(st + SW * k)));
            chk({tag, " slot"}, 64'(rx_slot[first + k]), 64'(k % 4));
        end
    endtask

    initial begin
        int wd;
        void'($urandom(32'h5eed_0042));

        // R11: reset state
        do_reset(1'b1, 1'b0, 1'b1);
        chk("R11 valid", 64'(out_valid), 64'd0);
        chk("R11 flags", 64'({err_late, err_early, err_overrun}), 64'd0);

        // R1: basic stream, rising sync, no offset, one-bit sync
        do_reset(1'b1, 1'b0, 1'b1);
        build(2, 1'b0, 1, 1'b1); play();
        chk("R1 count", 64'(rx_cnt), 64'd8);
        check_beats("R1", 0, 1, 8);
        chk("R6 no late on good stream", 64'(err_late), 64'd0);
        chk("R7 no early on good stream", 64'(err_early), 64'd0);

        // R3: wide sync of random width, trailing edge mid-frame ignored
        wd = $urandom_range(2, 120);
        do_reset(1'b1, 1'b0, 1'b1);
        build(2, 1'b0, wd, 1'b1); play();
        chk("R3 count", 64'(rx_cnt), 64'd8);
        check_beats("R3", 0, 1, 8);
        chk("R3 no early", 64'(err_early), 64'd0);

        // R2: falling active sync
        do_reset(1'b0, 1'b0, 1'b1);
        build(2, 1'b0, 5, 1'b0); play();
        chk("R2 count", 64'(rx_cnt), 64'd8);
        check_beats("R2", 0, 1, 8);

        // R4: stream with one-bit offset, matching config
        do_reset(1'b1, 1'b1, 1'b1);
        build(2, 1'b1, 3, 1'b1); play();
        chk("R4 count", 64'(rx_cnt), 64'd8);
        check_beats("R4", 0, 1, 8);
        chk("R4 no errors", 64'({err_late, err_early}), 64'd0);

        // R5: stream without offset, config expects offset -> one bit late
        do_reset(1'b1, 1'b1, 1'b1);
        build(2, 1'b0, 1, 1'b1); play();
        chk("R5 late-shift count", 64'(rx_cnt), 64'd7);
        check_beats("R5 late-shift", 0, 2, 7);

        // R5: stream with offset, config expects none -> one bit early
        do_reset(1'b1, 1'b0, 1'b1);
        build(2, 1'b1, 1, 1'b1); play();
        chk("R5 early-shift count", 64'(rx_cnt), 64'd8);
        check_beats("R5 early-shift", 0, 0, 8);

        // R8: sample on falling bit-clock edge
        do_reset(1'b1, 1'b0, 1'b0);
        build(2, 1'b0, 2, 1'b1); play();
        chk("R8 count", 64'(rx_cnt), 64'd8);
        check_beats("R8", 0, 1, 8);

        // R6: sync missing after one frame, then 40 more bits are dropped
        do_reset(1'b1, 1'b0, 1'b1);
        build(1, 1'b0, 1, 1'b1);
        for (int i = 0; i < 40; i++) push(1'b0, rbit());
        play();
        chk("R6 late flag", 64'(err_late), 64'd1);
        chk("R6 early flag", 64'(err_early), 64'd0);
        chk("R6 beats", 64'(rx_cnt), 64'd4);
        check_beats("R6", 0, 1, 4);
        // R9: sticky, then cleared by one-cycle pulse
        repeat (20) @(negedge clk);
        chk("R9 sticky", 64'(err_late), 64'd1);
        err_clear = 1'b1; @(negedge clk); err_clear = 1'b0;
        @(negedge clk);
        chk("R9 cleared", 64'(err_late), 64'd0);

        // R7: sync again after 80 bits; partial slot 2 dropped
        do_reset(1'b1, 1'b0, 1'b1);
        nb = 0;
        push(1'b0, rbit());
        add_frame(80, 1'b0, 1, 1'b1, 1'b0);
        add_frame(FL, 1'b0, 1, 1'b1, 1'b0);
        play();
        chk("R7 early flag", 64'(err_early), 64'd1);
        chk("R7 late flag", 64'(err_late), 64'd0);
        chk("R7 beats", 64'(rx_cnt), 64'd6);
        check_beats("R7 first", 0, 1, 2);
        check_beats("R7 restart", 2, 81, 4);

        // R10: consumer stalled for a full frame
        do_reset(1'b1, 1'b0, 1'b1);
        @(posedge clk); #1 out_ready = 1'b0;
        build(1, 1'b0, 1, 1'b1); play();
        chk("R10 overrun", 64'(err_overrun), 64'd1);
        chk("R10 held valid", 64'(out_valid), 64'd1);
        chk("R10 newest data", 64'(out_data), 64'(ext(1 + 3 * SW)));
        chk("R10 newest slot", 64'(out_slot), 64'd3);
        chk("R10 none taken", 64'(rx_cnt), 64'd0);
        @(posedge clk); #1 out_ready = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 one taken", 64'(rx_cnt), 64'd1);
        chk("R10 valid drops", 64'(out_valid), 64'd0);
        err_clear = 1'b1; @(negedge clk); err_clear = 1'b0;
        @(negedge clk);
        chk("R9 overrun cleared", 64'(err_overrun), 64'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule